// File: doc/BRIEF.md
# Data Storage Exception Checker

This block sits beside the load/store pipeline of a processor core and checks every load or cache-locking operation it receives against the current machine state and the read permissions of the page being accessed. The state inputs are the problem-state (user mode) bit, the guest-state bit and the user cache-lock enable bit, plus a cache-lock protect bit that the hypervisor controls. The block also takes the operation class and the page's user-read and supervisor-read permission bits. When a check fails, and no higher-priority exception is pending for the same operation, the block raises a one-cycle exception strobe and writes a 64-bit syndrome word. The word goes to one of two syndrome registers: a guest register when the guest-state bit is set, and a base register otherwise.

Cache-locking operations are checked only in user mode. Whether they fault depends on the hypervisor protect bit and the guest-state bit together. Data-cache and instruction-cache locking faults set different syndrome bits. The block does not handle address translation, interrupt vectoring, prioritization against other exception types, or the store and execute permission checks.

Top module: `dse_checker`

## Requirements
- R1: A cache-locking operation (class 2'b10 data-cache lock, class 2'b11 instruction-cache lock) with problem state 0 never raises an exception.
- R2: In user mode (problem state 1), a cache-locking operation faults whenever the hypervisor protect bit is 1 and guest state is 1, whatever the user cache-lock enable bit is.
- R3: In user mode, when the protect bit is 0 or guest state is 0, a cache-locking operation faults exactly when the user cache-lock enable bit is 0.
- R4: A data-cache lock fault writes a syndrome word in which only bit 42 is 1. Bits are numbered with bit 0 as the most significant, so bit 42 is vector index 21.
- R5: An instruction-cache lock fault writes a syndrome word in which only bit 43 (vector index 20) is 1.
- R6: A load (class 2'b01) in user mode to a page whose user-read bit is 0 faults and writes an all-zero syndrome word.
- R7: A load in supervisor mode to a page whose supervisor-read bit is 0 faults and writes an all-zero syndrome word. The user-read bit has no effect on a supervisor-mode load.
- R8: When the higher-priority-pending input is 1, no exception is raised and neither syndrome register changes.
- R9: A fault writes the guest syndrome register when guest state is 1 and the base register when it is 0. The other register keeps its value.
- R10: The exception strobe and the syndrome write appear on the clock edge that follows the request, and the strobe lasts exactly one cycle for each faulting request.
- R11: With the request valid input at 0, no exception is raised and both syndrome registers keep their values.
- R12: A synchronous active-high reset clears the exception strobe and both syndrome registers.
- R13: Class 2'b00 (any other operation) never faults, whatever the permission bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid for this cycle |
| op_class | input | 2 | 00 other, 01 load, 10 data-cache lock, 11 instruction-cache lock |
| st_user | input | 1 | Problem state (1 = user mode) |
| st_guest | input | 1 | Guest state |
| st_ulock_en | input | 1 | User cache-lock enable |
| hv_lock_prot | input | 1 | Hypervisor user cache-lock protect bit |
| pg_user_rd | input | 1 | Page user-read permission |
| pg_sup_rd | input | 1 | Page supervisor-read permission |
| hi_pri_pend | input | 1 | Higher-priority exception pending for this operation |
| exc_o | output | 1 | Data storage exception strobe |
| syn_base_o | output | 64 | Base syndrome register |
| syn_guest_o | output | 64 | Guest syndrome register |

## Verification
Any wrong decision in the checker shows up at the ports on the clock edge after the request. It appears as a missing or extra strobe on exc_o, or as a syndrome word with the wrong bit set. A wrong choice of target register shows on that same edge: one syndrome output changes when it should have held. A stuck or stale syndrome stays visible until the next fault, so each vector sets up a register value that the following fault must overwrite. The later checks then expose any failure to update.

// File: rtl/dse_pkg.sv
package dse_pkg;

    localparam int SYN_W      = 64;
    localparam int DLOCK_BIT  = 42;
    localparam int ILOCK_BIT  = 43;

    typedef enum logic [1:0] {
        OP_OTHER = 2'b00,
        OP_LOAD  = 2'b01,
        OP_DLOCK = 2'b10,
        OP_ILOCK = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_DLOCK = 2'b01,
        CAUSE_ILOCK = 2'b10,
        CAUSE_READ  = 2'b11
    } cause_e;

    typedef struct packed {
        logic user;
        logic guest;
        logic ulock_en;
        logic hv_prot;
    } mstate_t;

    typedef struct packed {
        logic user_rd;
        logic sup_rd;
    } perm_t;

    // Converts a big-endian bit number into a vector index.
    function automatic int msb0_idx(input int bitnum);
        return SYN_W - 1 - bitnum;
    endfunction

    function automatic logic [SYN_W-1:0] syn_word(input cause_e c);
        logic [SYN_W-1:0] w;
        w = '0;
        case (c)
            CAUSE_DLOCK: w[msb0_idx(DLOCK_BIT)] = 1'b1;
            CAUSE_ILOCK: w[msb0_idx(ILOCK_BIT)] = 1'b1;
            default:     w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/dse_lock_chk.sv
module dse_lock_chk
    import dse_pkg::*;
(
    input  op_class_e op,
    input  mstate_t   ms,
    output logic      lock_fault,
    output cause_e    lock_cause
);
    logic is_lock;
    logic denied;

    always_comb begin
        is_lock = (op == OP_DLOCK) || (op == OP_ILOCK);
        if (ms.hv_prot && ms.guest)
            denied = 1'b1;
        else
            denied = !ms.ulock_en;
        lock_fault = is_lock && ms.user && denied;
        if (!lock_fault)
            lock_cause = CAUSE_NONE;
        else if (op == OP_DLOCK)
            lock_cause = CAUSE_DLOCK;
        else
            lock_cause = CAUSE_ILOCK;
    end
endmodule

// File: rtl/dse_read_chk.sv
module dse_read_chk
    import dse_pkg::*;
(
    input  op_class_e op,
    input  logic      user,
    input  perm_t     perm,
    output logic      read_fault
);
    logic allowed;

    always_comb begin
        allowed    = user ? perm.user_rd : perm.sup_rd;
        read_fault = (op == OP_LOAD) && !allowed;
    end
endmodule

// File: rtl/dse_syn_reg.sv
module dse_syn_reg
    import dse_pkg::*;
#(
    parameter int   W        = SYN_W,
    parameter logic FOR_GUEST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         guest,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic sel;
    assign sel = wr_en && (guest == FOR_GUEST);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (sel)
            q <= wdata;
    end
endmodule

// File: rtl/dse_checker.sv
module dse_checker
    import dse_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       op_class,
    input  logic             st_user,
    input  logic             st_guest,
    input  logic             st_ulock_en,
    input  logic             hv_lock_prot,
    input  logic             pg_user_rd,
    input  logic             pg_sup_rd,
    input  logic             hi_pri_pend,
    output logic             exc_o,
    output logic [SYN_W-1:0] syn_base_o,
    output logic [SYN_W-1:0] syn_guest_o
);
    localparam int NREG = 2;

    op_class_e        op;
    mstate_t          ms;
    perm_t            perm;
    logic             lock_fault;
    cause_e           lock_cause;
    logic             read_fault;
    cause_e           cause;
    logic             take;
    logic [SYN_W-1:0] wword;
    logic [SYN_W-1:0] syn_q [NREG];
    logic             exc_q;

    assign op   = op_class_e'(op_class);
    assign ms   = '{user: st_user, guest: st_guest, ulock_en: st_ulock_en, hv_prot: hv_lock_prot};
    assign perm = '{user_rd: pg_user_rd, sup_rd: pg_sup_rd};

    dse_lock_chk u_lock (
        .op         (op),
        .ms         (ms),
        .lock_fault (lock_fault),
        .lock_cause (lock_cause)
    );

    dse_read_chk u_read (
        .op         (op),
        .user       (st_user),
        .perm       (perm),
        .read_fault (read_fault)
    );

    always_comb begin
        if (lock_fault)
            cause = lock_cause;
        else if (read_fault)
            cause = CAUSE_READ;
        else
            cause = CAUSE_NONE;
        take  = req_valid && !hi_pri_pend && (cause != CAUSE_NONE);
        wword = syn_word(cause);
    end

    always_ff @(posedge clk) begin
        if (rst)
            exc_q <= 1'b0;
        else
            exc_q <= take;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_syn
        dse_syn_reg #(
            .W         (SYN_W),
            .FOR_GUEST (g[0])
        ) u_reg (
            .clk   (clk),
            .rst   (rst),
            .wr_en (take),
            .guest (st_guest),
            .wdata (wword),
            .q     (syn_q[g])
        );
    end

    assign exc_o       = exc_q;
    assign syn_base_o  = syn_q[0];
    assign syn_guest_o = syn_q[1];
endmodule

// File: rtl/dse_checker_sva.sv
module dse_checker_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  op_class,
    input logic        st_user,
    input logic        st_guest,
    input logic        hi_pri_pend,
    input logic        exc_o,
    input logic [63:0] syn_base_o,
    input logic [63:0] syn_guest_o
);
    // R1
    supervisor_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (op_class[1] && !st_user) |=> !exc_o);

    // R4
    base_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(syn_base_o));

    // R5
    guest_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(syn_guest_o));

    // R8
    higher_pri_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && hi_pri_pend) |=> (!exc_o && $stable(syn_base_o) && $stable(syn_guest_o)));

    // R9
    guest_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && st_guest) |=> $stable(syn_base_o));

    // R9
    base_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !st_guest) |=> $stable(syn_guest_o));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!exc_o && $stable(syn_base_o) && $stable(syn_guest_o)));

    // R13
    other_class_chk: assert property (@(posedge clk) disable iff (rst)
        (op_class == 2'b00) |=> !exc_o);
endmodule

bind dse_checker dse_checker_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .op_class    (op_class),
    .st_user     (st_user),
    .st_guest    (st_guest),
    .hi_pri_pend (hi_pri_pend),
    .exc_o       (exc_o),
    .syn_base_o  (syn_base_o),
    .syn_guest_o (syn_guest_o)
);

// File: tb/dse_checker_bench.sv
`timescale 1ns/1ps
module dse_checker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  op_class = 2'b00;
    logic        st_user = 1'b0;
    logic        st_guest = 1'b0;
    logic        st_ulock_en = 1'b0;
    logic        hv_lock_prot = 1'b0;
    logic        pg_user_rd = 1'b1;
    logic        pg_sup_rd = 1'b1;
    logic        hi_pri_pend = 1'b0;
    logic        exc_o;
    logic [63:0] syn_base_o;
    logic [63:0] syn_guest_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dse_checker u_dse_checker (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .op_class     (op_class),
        .st_user      (st_user),
        .st_guest     (st_guest),
        .st_ulock_en  (st_ulock_en),
        .hv_lock_prot (hv_lock_prot),
        .pg_user_rd   (pg_user_rd),
        .pg_sup_rd    (pg_sup_rd),
        .hi_pri_pend  (hi_pri_pend),
        .exc_o        (exc_o),
        .syn_base_o   (syn_base_o),
        .syn_guest_o  (syn_guest_o)
    );

    // Fields: [12] valid [11:10] class [9] user [8] guest [7] ulock_en
    // [6] hv_prot [5] user_rd [4] sup_rd [3] hi_pri | [2] exp_exc [1:0] cause
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        13'b1_10_1_0_0_1_1_1_0_1_01, // R3 protect on, guest off, enable 0 -> data lock
        13'b1_01_1_0_0_0_0_1_0_1_11, // R6 user load, no user read
        13'b1_01_1_0_0_0_1_0_0_0_00, // R7 user load ignores supervisor read
        13'b1_10_1_0_0_0_1_1_0_1_01, // R3 protect off, enable 0 -> data lock
        13'b1_01_0_0_0_0_1_0_0_1_11, // R7 supervisor load, no supervisor read
        13'b1_01_0_0_0_0_0_1_0_0_00, // R7 supervisor load ignores user read
        13'b1_10_0_0_0_0_1_1_0_0_00, // R1 data lock in supervisor mode
        13'b1_11_0_1_0_1_1_1_0_0_00, // R1 instr lock in supervisor mode
        13'b1_11_1_1_1_1_1_1_0_1_10, // R2 protect and guest, enable 1 -> instr lock, guest reg
        13'b1_10_1_0_1_1_1_1_0_0_00, // R3 protect on, guest off, enable 1
        13'b1_11_1_1_1_0_1_1_0_0_00, // R3 protect off, guest on, enable 1
        13'b1_10_1_1_0_0_1_1_0_1_01, // R4 data lock into guest reg
        13'b1_11_1_0_0_1_1_1_1_0_00, // R8 higher priority pending
        13'b0_11_1_1_0_0_1_1_0_0_00, // R11 valid low
        13'b1_00_1_1_0_0_0_0_0_0_00, // R13 other class
        13'b1_11_1_0_0_0_1_1_0_1_10, // R5 instr lock into base reg
        13'b1_01_1_1_0_0_0_1_0_1_11, // R6 user load, guest reg cleared
        13'b1_01_0_0_0_0_1_0_1_0_00  // R8 higher priority hides read fault
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 3, 9, 10: return "R3";
            1, 16:       return "R6";
            2, 4, 5:     return "R7";
            6, 7:        return "R1";
            8:           return "R2";
            11:          return "R4";
            12, 17:      return "R8";
            13:          return "R11";
            14:          return "R13";
            default:     return "R5";
        endcase
    endfunction

    function automatic logic [63:0] exp_word(input logic [1:0] c);
        if (c == 2'd1) return 64'h1 << (63 - 42);
        if (c == 2'd2) return 64'h1 << (63 - 43);
        return 64'h0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [12:0] v);
        req_valid    = v[12];
        op_class     = v[11:10];
        st_user      = v[9];
        st_guest     = v[8];
        st_ulock_en  = v[7];
        hv_lock_prot = v[6];
        pg_user_rd   = v[5];
        pg_sup_rd    = v[4];
        hi_pri_pend  = v[3];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] m_base;
        logic [63:0] m_guest;
        m_base  = '0;
        m_guest = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "exc", {63'b0, exc_o}, 64'h0);
        check("R12", "base", syn_base_o, 64'h0);
        check("R12", "guest", syn_guest_o, 64'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            if (VEC[i][2]) begin
                if (VEC[i][8]) m_guest = exp_word(VEC[i][1:0]);
                else           m_base  = exp_word(VEC[i][1:0]);
            end
            check(tag_of(i), "exc", {63'b0, exc_o}, {63'b0, VEC[i][2]});
            check(tag_of(i), "base", syn_base_o, m_base);
            check(tag_of(i), "guest", syn_guest_o, m_guest);
        end

        // R10: strobe is a single-cycle pulse
        drive(13'b1_10_1_0_0_0_1_1_0_1_01);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "exc first cycle", {63'b0, exc_o}, 64'h1);
        check("R10", "base written same edge", syn_base_o, exp_word(2'd1));
        @(negedge clk);
        check("R10", "exc second cycle", {63'b0, exc_o}, 64'h0);

        // R12: reset in mid-run clears both registers
        drive(13'b1_11_1_1_0_0_1_1_0_1_10);
        @(negedge clk);
        check("R9", "guest written", syn_guest_o, exp_word(2'd2));
        rst = 1'b1;
        @(negedge clk);
        check("R12", "exc after reset", {63'b0, exc_o}, 64'h0);
        check("R12", "base after reset", syn_base_o, 64'h0);
        check("R12", "guest after reset", syn_guest_o, 64'h0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule